// File: doc/BRIEF.md
# Exposed Load Tracker and Violation Filter

This block sits beside a speculative data cache and sorts each load into one of two kinds. A load is exposed when the current epoch has not already written the word it reads. For every cache line slot the block keeps one flag per word, and a speculative store sets the flag for its word. An exposed load reads a value that an older epoch may still overwrite, so it is the only kind of load that can later be hit by a dependence violation.

The coherence logic reports violations only by the tag of the line, so the block has to map that tag back to a load. Each exposed load writes its program counter into a small direct-mapped table. The table is indexed by the low bits of the line tag and also holds the remaining tag bits. When a violation arrives for a line, the block looks up its entry. On a match, the stored program counter goes into a short fully-associative list of loads that have caused violations.

A value predictor uses the query port to ask whether a given program counter is in that list, and it can then limit prediction to loads with a history of violations. The block does not hold the cache data and does not detect violations.

Top module: `exposed_load_filter`

## Requirements
- R1: A store (`acc_valid`=1, `acc_store`=1) sets the flag of its word in slot `acc_line`. A later load of that same slot and word in the same epoch reports `ld_exposed`=0. A store never raises `ld_done`.
- R2: A load (`acc_valid`=1, `acc_store`=0) raises `ld_done` in the next cycle. `ld_exposed` is 1 there only when its word flag was clear, and flags of other words or other slots have no effect.
- R3: `epoch_clear` clears every word flag at the clock edge. A store in the same cycle is not recorded, and a load in the same cycle is classified with the flags as they stood before the clear.
- R4: An exposed load writes its PC into table entry `acc_tag[3:0]` (with 16 entries). The entry is marked valid and keeps `acc_tag` bits above bit 3. Stores and loads that are not exposed leave the table unchanged.
- R5: A violation (`viol_valid`=1) reads table entry `viol_tag[3:0]`. If that entry is valid and its stored upper tag bits equal those of `viol_tag`, its PC enters the violating-loads list.
- R6: A violation whose entry is invalid, or whose upper tag bits differ, adds nothing to the list.
- R7: Inserting a PC that the list already holds changes nothing, and it does not use up a replacement slot.
- R8: The list holds `LIST_N` PCs (8 by default). Once it is full, a new insert replaces the entry that was inserted earliest, in round-robin order.
- R9: When a load and a violation with the same table index arrive in the same cycle, the violation uses the entry as it was before the load's write.
- R10: A query (`qry_valid`=1) gives `qry_done`=1 in the next cycle. `qry_hit` then shows whether `qry_pc` was in the list before that clock edge. Without a query, both outputs are 0.
- R11: After the synchronous reset, all flags, table entries and list entries are cleared, and `ld_done`, `ld_exposed`, `qry_done` and `qry_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A cache access is present this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_line | input | LINE_IW (6) | Cache line slot of the access |
| acc_tag | input | TAG_W (20) | Tag of the accessed line |
| acc_word | input | WORD_IW (3) | Word within the line |
| acc_pc | input | PC_W (32) | Program counter of the access |
| epoch_clear | input | 1 | The epoch has committed or been squashed |
| viol_valid | input | 1 | Dependence violation reported this cycle |
| viol_tag | input | TAG_W (20) | Tag of the violated line |
| qry_valid | input | 1 | Membership query present |
| qry_pc | input | PC_W (32) | PC to look up in the list |
| ld_done | output | 1 | A load was classified in the previous cycle |
| ld_exposed | output | 1 | That load was exposed |
| qry_done | output | 1 | A query answer is present |
| qry_hit | output | 1 | The queried PC is in the list |

## Verification
Two functions can fall in the same cycle. A load can write a table entry while a violation reads that same entry, and an epoch clear can land together with an access. The bench provokes the first case with a directed pair: a second exposed load to a tag that already has an entry, given in the same cycle as a violation on that tag. Queries afterwards must find the earlier PC and not the newer one. Random traffic over a small set of tags produces many more of these collisions. Every classification and every query answer is compared with a reference model in the bench. That model updates in the required order: violation read, then table write, then the clear, which takes priority over a store.

// File: rtl/elf_pkg.sv
package elf_pkg;
  // Kind of cache access seen by the tracker.
  typedef enum logic {ACC_LOAD = 1'b0, ACC_STORE = 1'b1} acc_kind_e;

  // Low tag bits used as the table index.
  function automatic int unsigned idx_bits(input int unsigned entries);
    return (entries > 1) ? $clog2(entries) : 1;
  endfunction
endpackage

// File: rtl/elf_word_marks.sv
module elf_word_marks #(
  parameter int LINES = 64,
  parameter int WORDS = 8,
  localparam int LINE_IW = elf_pkg::idx_bits(LINES),
  localparam int WORD_IW = elf_pkg::idx_bits(WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               set_en,
  input  logic [LINE_IW-1:0] line,
  input  logic [WORD_IW-1:0] word,
  output logic               mark
);
  logic [WORDS-1:0] marks [LINES];

  assign mark = marks[line][word];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int i = 0; i < LINES; i++) marks[i] <= '0;
    end else if (set_en) begin
      marks[line][word] <= 1'b1;
    end
  end
endmodule

// File: rtl/elf_pc_table.sv
module elf_pc_table #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 20,
  parameter int PC_W    = 32,
  localparam int IW     = elf_pkg::idx_bits(ENTRIES),
  localparam int PT_W   = TAG_W - IW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PC_W-1:0]  lk_pc
);
  logic [PC_W-1:0]  pc_mem [ENTRIES];
  logic [PT_W-1:0]  pt_mem [ENTRIES];
  logic [ENTRIES-1:0] vld;

  logic [IW-1:0] wr_idx, lk_idx;
  assign wr_idx = wr_tag[IW-1:0];
  assign lk_idx = lk_tag[IW-1:0];

  // Data arrays carry no reset so they can map to distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      pc_mem[wr_idx] <= wr_pc;
      pt_mem[wr_idx] <= wr_tag[TAG_W-1:IW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  // Asynchronous read sees the contents before this cycle's write.
  assign lk_pc  = pc_mem[lk_idx];
  assign lk_hit = vld[lk_idx] && (pt_mem[lk_idx] == lk_tag[TAG_W-1:IW]);
endmodule

// File: rtl/elf_viol_list.sv
module elf_viol_list #(
  parameter int LIST_N = 8,
  parameter int PC_W   = 32,
  localparam int RR_W  = elf_pkg::idx_bits(LIST_N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_en,
  input  logic [PC_W-1:0] ins_pc,
  input  logic [PC_W-1:0] qry_pc,
  output logic            qry_hit
);
  logic [PC_W-1:0]   pcs [LIST_N];
  logic [LIST_N-1:0] vld;
  logic [LIST_N-1:0] ins_match, qry_match;
  logic [RR_W-1:0]   rr;
  logic              dup;

  for (genvar g = 0; g < LIST_N; g++) begin : g_cmp
    assign ins_match[g] = vld[g] && (pcs[g] == ins_pc);
    assign qry_match[g] = vld[g] && (pcs[g] == qry_pc);
  end

  assign dup     = |ins_match;
  assign qry_hit = |qry_match;

  always_ff @(posedge clk) begin
    if (ins_en && !dup) pcs[rr] <= ins_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      rr  <= '0;
    end else if (ins_en && !dup) begin
      vld[rr] <= 1'b1;
      rr      <= (rr == RR_W'(LIST_N - 1)) ? '0 : rr + 1'b1;
    end
  end
endmodule

// File: rtl/exposed_load_filter.sv
module exposed_load_filter #(
  parameter int LINES   = 64,
  parameter int WORDS   = 8,
  parameter int TAG_W   = 20,
  parameter int PC_W    = 32,
  parameter int TBL_N   = 16,
  parameter int LIST_N  = 8,
  localparam int LINE_IW = elf_pkg::idx_bits(LINES),
  localparam int WORD_IW = elf_pkg::idx_bits(WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic               acc_store,
  input  logic [LINE_IW-1:0] acc_line,
  input  logic [TAG_W-1:0]   acc_tag,
  input  logic [WORD_IW-1:0] acc_word,
  input  logic [PC_W-1:0]    acc_pc,
  input  logic               epoch_clear,
  input  logic               viol_valid,
  input  logic [TAG_W-1:0]   viol_tag,
  input  logic               qry_valid,
  input  logic [PC_W-1:0]    qry_pc,
  output logic               ld_done,
  output logic               ld_exposed,
  output logic               qry_done,
  output logic               qry_hit
);
  import elf_pkg::*;

  logic is_load, is_store, word_mark, exposed;
  logic tbl_hit, list_hit;
  logic [PC_W-1:0] tbl_pc;

  assign is_load  = acc_valid && (acc_kind_e'(acc_store) == ACC_LOAD);
  assign is_store = acc_valid && (acc_kind_e'(acc_store) == ACC_STORE);
  assign exposed  = is_load && !word_mark;

  elf_word_marks #(.LINES(LINES), .WORDS(WORDS)) u_marks (
    .clk(clk), .rst(rst), .clear(epoch_clear), .set_en(is_store),
    .line(acc_line), .word(acc_word), .mark(word_mark)
  );

  elf_pc_table #(.ENTRIES(TBL_N), .TAG_W(TAG_W), .PC_W(PC_W)) u_table (
    .clk(clk), .rst(rst), .wr_en(exposed), .wr_tag(acc_tag), .wr_pc(acc_pc),
    .lk_tag(viol_tag), .lk_hit(tbl_hit), .lk_pc(tbl_pc)
  );

  elf_viol_list #(.LIST_N(LIST_N), .PC_W(PC_W)) u_list (
    .clk(clk), .rst(rst), .ins_en(viol_valid && tbl_hit), .ins_pc(tbl_pc),
    .qry_pc(qry_pc), .qry_hit(list_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_done    <= 1'b0;
      ld_exposed <= 1'b0;
      qry_done   <= 1'b0;
      qry_hit    <= 1'b0;
    end else begin
      ld_done    <= is_load;
      ld_exposed <= exposed;
      qry_done   <= qry_valid;
      qry_hit    <= qry_valid && list_hit;
    end
  end
endmodule

// File: rtl/exposed_load_filter_chk.sv
module exposed_load_filter_chk (
  input logic clk,
  input logic rst,
  input logic acc_valid,
  input logic acc_store,
  input logic epoch_clear,
  input logic qry_valid,
  input logic ld_done,
  input logic ld_exposed,
  input logic qry_done,
  input logic qry_hit
);
  p_store_silent_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_store) |=> !ld_done && !ld_exposed);

  p_load_reported_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_store) |=> ld_done);

  p_fresh_epoch_r3: assert property (@(posedge clk) disable iff (rst)
    epoch_clear ##1 (acc_valid && !acc_store) |=> ld_exposed);

  p_answer_next_r10: assert property (@(posedge clk) disable iff (rst)
    qry_valid |=> qry_done);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !qry_valid |=> !qry_done && !qry_hit);

  p_reset_clean_r11: assert property (@(posedge clk)
    $past(rst) |-> !ld_done && !ld_exposed && !qry_done && !qry_hit);
endmodule

bind exposed_load_filter exposed_load_filter_chk u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_store(acc_store),
  .epoch_clear(epoch_clear), .qry_valid(qry_valid), .ld_done(ld_done),
  .ld_exposed(ld_exposed), .qry_done(qry_done), .qry_hit(qry_hit)
);

// File: tb/exposed_load_filter_tb.sv
module exposed_load_filter_tb;
  localparam int LINES = 64, WORDS = 8, TAG_W = 20, PC_W = 32;
  localparam int TBL_N = 16, LIST_N = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic acc_valid = 0, acc_store = 0, epoch_clear = 0, viol_valid = 0, qry_valid = 0;
  logic [5:0] acc_line = '0;
  logic [TAG_W-1:0] acc_tag = '0, viol_tag = '0;
  logic [2:0] acc_word = '0;
  logic [PC_W-1:0] acc_pc = '0, qry_pc = '0;
  logic ld_done, ld_exposed, qry_done, qry_hit;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  exposed_load_filter #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W), .PC_W(PC_W),
    .TBL_N(TBL_N), .LIST_N(LIST_N)) u_dut (.*);

  // Reference model
  bit m_mark [LINES][WORDS];
  bit m_tv [TBL_N];
  int unsigned m_tpt [TBL_N];
  logic [PC_W-1:0] m_tpc [TBL_N];
  bit m_lv [LIST_N];
  logic [PC_W-1:0] m_lpc [LIST_N];
  int m_rr;

  function automatic bit list_has(input logic [PC_W-1:0] pc);
    for (int i = 0; i < LIST_N; i++) if (m_lv[i] && m_lpc[i] == pc) return 1;
    return 0;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < LINES; i++) for (int j = 0; j < WORDS; j++) m_mark[i][j] = 0;
    for (int i = 0; i < TBL_N; i++) m_tv[i] = 0;
    for (int i = 0; i < LIST_N; i++) m_lv[i] = 0;
    m_rr = 0;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1; acc_valid = 0; viol_valid = 0; qry_valid = 0; epoch_clear = 0;
    @(posedge clk); @(posedge clk); #1;
    check("R11", ld_done, 1'b0, "ld_done");
    check("R11", qry_done, 1'b0, "qry_done");
    @(negedge clk); rst = 0;
    model_reset();
  endtask

  // One cycle: drive at negedge, update model, compare after posedge.
  task automatic cyc(input bit av, input bit st, input int idx, input logic [TAG_W-1:0] tag,
                     input int wd, input logic [PC_W-1:0] pc, input bit clr,
                     input bit vv, input logic [TAG_W-1:0] vt,
                     input bit qv, input logic [PC_W-1:0] qp, input string req);
    bit e_ld, e_ex, e_qh;
    int e;
    acc_valid = av; acc_store = st; acc_line = 6'(idx); acc_tag = tag; acc_word = 3'(wd);
    acc_pc = pc; epoch_clear = clr; viol_valid = vv; viol_tag = vt; qry_valid = qv; qry_pc = qp;
    e_ld = av && !st;
    e_ex = e_ld && !m_mark[idx][wd];
    e_qh = qv && list_has(qp);
    if (vv) begin
      e = int'(vt % TBL_N);
      if (m_tv[e] && m_tpt[e] == int'(vt / TBL_N) && !list_has(m_tpc[e])) begin
        m_lv[m_rr] = 1; m_lpc[m_rr] = m_tpc[e]; m_rr = (m_rr + 1) % LIST_N;
      end
    end
    if (e_ex) begin
      e = int'(tag % TBL_N);
      m_tv[e] = 1; m_tpt[e] = int'(tag / TBL_N); m_tpc[e] = pc;
    end
    if (clr) begin
      for (int i = 0; i < LINES; i++) for (int j = 0; j < WORDS; j++) m_mark[i][j] = 0;
    end else if (av && st) m_mark[idx][wd] = 1;
    @(posedge clk); #1;
    check(req, ld_done, e_ld, "ld_done");
    check(req, ld_exposed, e_ex, "ld_exposed");
    check(req, qry_done, qv, "qry_done");
    check(req, qry_hit, e_qh, "qry_hit");
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  task automatic query(input logic [PC_W-1:0] p, input string req);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, p, req);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    do_reset();
    query(32'h0, "R11");

    // R2: load to an unwritten word is exposed.
    cyc(1, 0, 3, 20'h00015, 2, 32'h100, 0, 0, 0, 0, 0, "R2");
    // R1: store then load of the same word is not exposed.
    cyc(1, 1, 3, 20'h00015, 5, 32'h104, 0, 0, 0, 0, 0, "R1");
    cyc(1, 0, 3, 20'h00015, 5, 32'h108, 0, 0, 0, 0, 0, "R1");
    // R2: neighbouring word and other slot stay exposed.
    cyc(1, 0, 3, 20'h00025, 4, 32'h10c, 0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 4, 20'h00036, 5, 32'h110, 0, 0, 0, 0, 0, "R2");
    // R4/R5: violation on tag 0x25 finds PC 0x10c; 0x100 was replaced in entry 5.
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 20'h00025, 0, 0, "R5");
    query(32'h10c, "R5");
    query(32'h100, "R4");
    query(32'h108, "R4");
    // R6: upper-tag mismatch and empty entry add nothing.
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 20'h00046, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 20'h00009, 0, 0, "R6");
    query(32'h110, "R6");
    query(32'h0, "R6");
    // R9: load and violation on the same entry in one cycle.
    cyc(1, 0, 7, 20'h00037, 0, 32'h200, 0, 0, 0, 0, 0, "R9");
    cyc(1, 0, 7, 20'h00037, 1, 32'h204, 0, 1, 20'h00037, 0, 0, "R9");
    query(32'h200, "R9");
    query(32'h204, "R9");
    // R3: clear with a store and a load in the same cycle.
    cyc(1, 1, 9, 20'h00001, 1, 32'h300, 0, 0, 0, 0, 0, "R3");
    cyc(1, 0, 9, 20'h00001, 1, 32'h304, 1, 0, 0, 0, 0, "R3");
    cyc(1, 0, 9, 20'h00001, 1, 32'h308, 0, 0, 0, 0, 0, "R3");
    cyc(1, 1, 9, 20'h00001, 2, 32'h30c, 1, 0, 0, 0, 0, "R3");
    cyc(1, 0, 9, 20'h00001, 2, 32'h310, 0, 0, 0, 0, 0, "R3");

    // R7/R8: fill, duplicate, then overflow.
    do_reset();
    for (int k = 0; k < LIST_N; k++) begin
      cyc(1, 0, k, 20'(k), 0, 32'h400 + 32'(k * 4), 0, 0, 0, 0, 0, "R8");
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 20'(k), 0, 0, "R8");
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 20'h00003, 0, 0, "R7");
    cyc(1, 0, 9, 20'h0000a, 0, 32'h500, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 20'h0000a, 0, 0, "R8");
    query(32'h400, "R8");
    query(32'h404, "R7");
    query(32'h500, "R8");
    idle();

    // Random traffic over a small tag space.
    for (int n = 0; n < 3000; n++) begin
      bit av, st, clr, vv, qv;
      int idx, wd;
      logic [TAG_W-1:0] tg, vt;
      logic [PC_W-1:0] pc, qp;
      av  = ($urandom % 10) < 7;
      st  = ($urandom % 10) < 4;
      idx = int'($urandom % 8);
      wd  = int'($urandom % WORDS);
      tg  = 20'((($urandom % 3) << 4) | ($urandom % 16));
      pc  = 32'h1000 + 32'(($urandom % 24) * 4);
      clr = ($urandom % 40) == 0;
      vv  = ($urandom % 5) == 0;
      vt  = ($urandom % 2) ? tg : 20'((($urandom % 3) << 4) | ($urandom % 16));
      qv  = ($urandom % 2) == 0;
      qp  = 32'h1000 + 32'(($urandom % 24) * 4);
      cyc(av, st, idx, tg, wd, pc, clr, vv, vt, qv, qp, "R2");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule